// File: doc/BRIEF.md
# Decode-Time Slice Store

This block keeps short instruction sequences (slices) that an upstream extractor has pulled out of the committed instruction stream. Each slice is filed under the address of its lead instruction, which is the oldest instruction in the slice. When the decode stage later presents that same address, the block hands back the stored opcodes so that a helper thread can be started from them. A slice is a variable-length list of opcodes that need not be adjacent in program memory. Each line therefore carries an explicit length as well as the opcodes.

Writes arrive as a burst, one opcode word per beat. The tag, length and valid bit are committed only on the final beat, so a lookup never sees a half-written line. A lookup is answered one cycle after it is accepted with a hit flag and a length. On a hit, the opcodes follow one per cycle from a private copy taken at lookup time. The store is four-way set-associative. It keeps at most one line per lead address and replaces lines by tree pseudo-LRU.

Top module: `slice_store`

## Requirements
- R1: After reset no line is valid: every lookup misses, `rsp_vld` and `op_vld` are low until a lookup is made, and all recency bits are 0.
- R2: A write burst starts with `wr_start` carrying `wr_pc`, `wr_cnt` and opcode 0 on `wr_op`. Opcodes 1 to `wr_cnt`-1 follow in order on later cycles where `wr_vld` is high, and idle cycles between beats are allowed. The line can be looked up from the cycle after the final beat. A `wr_start` during a burst is ignored.
- R3: A lookup (`lk_req`) is accepted when no hit stream is in progress. In the next cycle `rsp_vld` is high for one cycle, with `rsp_hit` and `rsp_cnt` (which is 0 on a miss). A miss produces no `op_vld`. A lookup made while `op_vld` is high is ignored and produces no response.
- R4: On a hit, `op_vld` is high for exactly `rsp_cnt` consecutive cycles, starting in the `rsp_vld` cycle. `op_data` carries opcodes 0, 1, 2 … in write order.
- R5: The set is `pc[2 +: log2(SETS)]`, each set has 4 ways, and a line matches only on the full lead address.
- R6: A set never holds two lines for one lead address. Writing a lead address that is already present overwrites that line in place and leaves the other ways untouched.
- R7: A new lead address fills the lowest-numbered invalid way. If all four ways are valid, the victim is chosen by 3 recency bits per set. Bit 0 selects the pair: 0 means ways 0–1, 1 means ways 2–3. Bit 1 picks within ways 0–1 (0 means way 0). Bit 2 picks within ways 2–3 (0 means way 2). Each write commit and each lookup hit on way w sets the bits on w's path to point away from w.
- R8: A lookup to the set of an accepted write burst returns a miss. This holds from the cycle of `wr_start` through the cycle of the final beat.
- R9: A write whose `wr_cnt` is 0 or greater than 16 is rejected. The store is left unchanged, and `wr_vld` beats that follow it are ignored.
- R10: A 16-opcode slice, the longest allowed, is stored and returned in full.
- R11: A hit stream returns the line as it was when the lookup was accepted, even if a write replaces that line while the stream is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_start | input | 1 | First beat of a write burst |
| wr_pc | input | PC_W | Lead address of the slice being written |
| wr_cnt | input | CNT_W | Number of opcodes in the slice |
| wr_vld | input | 1 | Later beat of a write burst |
| wr_op | input | OP_W | Opcode word for the current beat |
| lk_req | input | 1 | Lookup request from decode |
| lk_pc | input | PC_W | Address being decoded |
| rsp_vld | output | 1 | Lookup response valid |
| rsp_hit | output | 1 | Lookup found a slice |
| rsp_cnt | output | CNT_W | Length of the found slice, 0 on a miss |
| op_vld | output | 1 | An opcode of the hit stream is on `op_data` |
| op_data | output | OP_W | Streamed opcode word |

## Verification
A wrong length or tag is visible in the response cycle itself, as a wrong `rsp_hit` or `rsp_cnt`. A corrupted opcode word shows up in the exact stream cycle that carries it. Recency errors stay hidden until a fifth distinct lead address lands in a full set, so the bench keeps a reference model and follows every eviction with lookups of all candidates. A missing conflict check or snapshot can only be seen when a lookup and a write overlap, so those cases are driven as concurrent bursts.

// File: rtl/slc_pkg.sv
package slc_pkg;
    localparam int WAYS  = 4;
    localparam int WAY_W = 2;

    typedef logic [2:0] rec_t;

    // Victim from tree bits: b[0] picks the pair, b[1]/b[2] pick within it.
    function automatic logic [WAY_W-1:0] rec_victim(input rec_t b);
        if (!b[0]) return b[1] ? 2'd1 : 2'd0;
        else       return b[2] ? 2'd3 : 2'd2;
    endfunction

    // Point all bits on the path of way w away from w.
    function automatic rec_t rec_touch(input rec_t b, input logic [WAY_W-1:0] w);
        rec_t r = b;
        r[0] = ~w[1];
        if (!w[1]) r[1] = ~w[0];
        else       r[2] = ~w[0];
        return r;
    endfunction
endpackage

// File: rtl/slc_way_match.sv
module slc_way_match
    import slc_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [WAYS-1:0]        vld,
    input  logic [WAYS*PC_W-1:0]   tags,
    input  logic [PC_W-1:0]        pc,
    output logic                   hit,
    output logic [WAY_W-1:0]       way
);
    logic [WAYS-1:0] eq;

    for (genvar g = 0; g < WAYS; g++) begin : g_cmp
        assign eq[g] = vld[g] && (tags[g*PC_W +: PC_W] == pc);
    end

    always_comb begin
        way = '0;
        for (int g = 0; g < WAYS; g++) begin
            if (eq[g]) way = WAY_W'(g);
        end
    end

    assign hit = |eq;

    AST_ONE_LINE_PER_LEAD: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(eq)); // R6
endmodule

// File: rtl/slc_data_ram.sv
module slc_data_ram
    import slc_pkg::*;
#(
    parameter int SETS    = 16,
    parameter int MAX_LEN = 16,
    parameter int OP_W    = 32,
    localparam int SET_W  = $clog2(SETS),
    localparam int IDX_W  = $clog2(MAX_LEN),
    localparam int LINE_W = MAX_LEN * OP_W
) (
    input  logic                clk,
    input  logic                we,
    input  logic [SET_W-1:0]    wset,
    input  logic [WAY_W-1:0]    wway,
    input  logic [IDX_W-1:0]    widx,
    input  logic [OP_W-1:0]     wdata,
    input  logic [SET_W-1:0]    rset,
    input  logic [WAY_W-1:0]    rway,
    output logic [LINE_W-1:0]   rline
);
    localparam int DEPTH = SETS * WAYS * MAX_LEN;

    logic [OP_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[{wset, wway, widx}] <= wdata;
    end

    for (genvar i = 0; i < MAX_LEN; i++) begin : g_rd
        assign rline[i*OP_W +: OP_W] = mem_q[{rset, rway, IDX_W'(i)}];
    end
endmodule

// File: rtl/slice_store.sv
module slice_store
    import slc_pkg::*;
#(
    parameter int PC_W    = 32,
    parameter int OP_W    = 32,
    parameter int SETS    = 16,
    parameter int MAX_LEN = 16,
    localparam int CNT_W  = $clog2(MAX_LEN + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_start,
    input  logic [PC_W-1:0]   wr_pc,
    input  logic [CNT_W-1:0]  wr_cnt,
    input  logic              wr_vld,
    input  logic [OP_W-1:0]   wr_op,
    input  logic              lk_req,
    input  logic [PC_W-1:0]   lk_pc,
    output logic              rsp_vld,
    output logic              rsp_hit,
    output logic [CNT_W-1:0]  rsp_cnt,
    output logic              op_vld,
    output logic [OP_W-1:0]   op_data
);
    localparam int SET_W  = $clog2(SETS);
    localparam int IDX_W  = $clog2(MAX_LEN);
    localparam int LINE_W = MAX_LEN * OP_W;

    typedef struct packed {
        logic              wbusy;
        logic [SET_W-1:0]  wset;
        logic [WAY_W-1:0]  wway;
        logic [PC_W-1:0]   wpc;
        logic [CNT_W-1:0]  wcnt;
        logic [CNT_W-1:0]  widx;
        logic              ract;
        logic [CNT_W-1:0]  ridx;
        logic [CNT_W-1:0]  rcnt;
        logic              rsp;
        logic              rhit;
        logic [LINE_W-1:0] line;
    } ctl_t;

    ctl_t s_d, s_q;

    // Line state
    logic [SETS-1:0][WAYS-1:0] vld_q;
    logic [PC_W-1:0]           tag_q [SETS][WAYS];
    logic [CNT_W-1:0]          cnt_q [SETS][WAYS];
    rec_t                      rec_q [SETS];

    // Lookup-side match
    logic [SET_W-1:0]       lk_set;
    logic [WAYS*PC_W-1:0]   lk_tags;
    logic                   lk_hit;
    logic [WAY_W-1:0]       lk_way;
    logic [LINE_W-1:0]      rd_line;

    // Write-side match
    logic [SET_W-1:0]       wr_set;
    logic [WAYS*PC_W-1:0]   wr_tags;
    logic                   wr_hit;
    logic [WAY_W-1:0]       wr_hit_way;

    assign lk_set = lk_pc[2 +: SET_W];
    assign wr_set = wr_pc[2 +: SET_W];

    for (genvar g = 0; g < WAYS; g++) begin : g_tags
        assign lk_tags[g*PC_W +: PC_W] = tag_q[lk_set][g];
        assign wr_tags[g*PC_W +: PC_W] = tag_q[wr_set][g];
    end

    slc_way_match #(.PC_W(PC_W)) u_lk_match (
        .clk(clk), .rst_n(rst_n), .vld(vld_q[lk_set]), .tags(lk_tags),
        .pc(lk_pc), .hit(lk_hit), .way(lk_way)
    );

    slc_way_match #(.PC_W(PC_W)) u_wr_match (
        .clk(clk), .rst_n(rst_n), .vld(vld_q[wr_set]), .tags(wr_tags),
        .pc(wr_pc), .hit(wr_hit), .way(wr_hit_way)
    );

    // Combinational next-state signals
    logic             wr_acc, lk_acc, lk_conf, lk_ok, touch;
    logic             free_ok;
    logic [WAY_W-1:0] free_way, new_way;
    logic             dw_en;
    logic [SET_W-1:0] dw_set;
    logic [WAY_W-1:0] dw_way;
    logic [IDX_W-1:0] dw_idx;
    logic [OP_W-1:0]  dw_data;
    logic             cm_en;
    logic [SET_W-1:0] cm_set;
    logic [WAY_W-1:0] cm_way;
    logic [PC_W-1:0]  cm_pc;
    logic [CNT_W-1:0] cm_cnt;

    slc_data_ram #(.SETS(SETS), .MAX_LEN(MAX_LEN), .OP_W(OP_W)) u_ram (
        .clk(clk), .we(dw_en), .wset(dw_set), .wway(dw_way), .widx(dw_idx),
        .wdata(dw_data), .rset(lk_set), .rway(lk_way), .rline(rd_line)
    );

    always_comb begin
        s_d     = s_q;
        s_d.rsp = 1'b0;

        // Write side: accept, pick a way, write words, commit on final beat.
        wr_acc = wr_start && !s_q.wbusy && (wr_cnt != '0)
                 && (wr_cnt <= CNT_W'(MAX_LEN));
        free_ok  = 1'b0;
        free_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!vld_q[wr_set][w]) begin
                free_ok  = 1'b1;
                free_way = WAY_W'(w);
            end
        end
        new_way = wr_hit  ? wr_hit_way :
                  free_ok ? free_way   : rec_victim(rec_q[wr_set]);

        dw_en = 1'b0;  dw_set = wr_set;  dw_way = new_way;
        dw_idx = '0;   dw_data = wr_op;
        cm_en = 1'b0;  cm_set = wr_set;  cm_way = new_way;
        cm_pc = wr_pc; cm_cnt = wr_cnt;

        if (wr_acc) begin
            dw_en = 1'b1;
            if (wr_cnt == CNT_W'(1)) begin
                cm_en = 1'b1;
            end else begin
                s_d.wbusy = 1'b1;
                s_d.wset  = wr_set;
                s_d.wway  = new_way;
                s_d.wpc   = wr_pc;
                s_d.wcnt  = wr_cnt;
                s_d.widx  = CNT_W'(1);
            end
        end else if (s_q.wbusy && wr_vld) begin
            dw_en    = 1'b1;
            dw_set   = s_q.wset;
            dw_way   = s_q.wway;
            dw_idx   = s_q.widx[IDX_W-1:0];
            s_d.widx = s_q.widx + 1'b1;
            if (s_q.widx == s_q.wcnt - 1'b1) begin
                cm_en     = 1'b1;
                cm_set    = s_q.wset;
                cm_way    = s_q.wway;
                cm_pc     = s_q.wpc;
                cm_cnt    = s_q.wcnt;
                s_d.wbusy = 1'b0;
            end
        end

        // Lookup side: stream advance, then accept a new lookup when idle.
        lk_conf = (s_q.wbusy && (lk_set == s_q.wset)) || (wr_acc && (lk_set == wr_set));
        lk_acc  = lk_req && !s_q.ract;
        lk_ok   = lk_hit && !lk_conf;
        touch   = 1'b0;

        if (s_q.ract) begin
            if (s_q.ridx == s_q.rcnt - 1'b1) s_d.ract = 1'b0;
            else                              s_d.ridx = s_q.ridx + 1'b1;
        end

        if (lk_acc) begin
            s_d.rsp  = 1'b1;
            s_d.rhit = lk_ok;
            s_d.ract = lk_ok;
            s_d.ridx = '0;
            s_d.rcnt = lk_ok ? cnt_q[lk_set][lk_way] : '0;
            if (lk_ok) s_d.line = rd_line;
            touch = lk_ok;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
            for (int i = 0; i < SETS; i++) rec_q[i] <= '0;
        end else begin
            if (touch) rec_q[lk_set] <= rec_touch(rec_q[lk_set], lk_way);
            if (cm_en) begin
                vld_q[cm_set][cm_way] <= 1'b1;
                tag_q[cm_set][cm_way] <= cm_pc;
                cnt_q[cm_set][cm_way] <= cm_cnt;
                rec_q[cm_set]         <= rec_touch(rec_q[cm_set], cm_way);
            end
        end
    end

    assign rsp_vld = s_q.rsp;
    assign rsp_hit = s_q.rsp & s_q.rhit;
    assign rsp_cnt = s_q.rsp ? s_q.rcnt : '0;
    assign op_vld  = s_q.ract;
    assign op_data = s_q.ract ? s_q.line[s_q.ridx[IDX_W-1:0]*OP_W +: OP_W] : '0;

    AST_CONFLICT_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_acc && lk_conf) |=> (rsp_vld && !rsp_hit)); // R8
    AST_MISS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_vld && !rsp_hit) |-> (!op_vld && rsp_cnt == '0)); // R3
    AST_HIT_STREAM: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_vld && rsp_hit) |-> (op_vld && rsp_cnt != '0 && rsp_cnt <= CNT_W'(MAX_LEN))); // R4
    AST_REJECT_NOOP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_start && !s_q.wbusy && (wr_cnt == '0 || wr_cnt > CNT_W'(MAX_LEN)))
        |=> (!s_q.wbusy && $stable(vld_q))); // R9
endmodule

// File: tb/tb_slice_store.sv
module tb_slice_store;
    localparam int PC_W = 32, OP_W = 32, SETS = 16, MAX_LEN = 16, CNT_W = 5, SET_W = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic wr_start = 0, wr_vld = 0, lk_req = 0;
    logic [PC_W-1:0] wr_pc = '0, lk_pc = '0;
    logic [CNT_W-1:0] wr_cnt = '0;
    logic [OP_W-1:0] wr_op = '0;
    logic rsp_vld, rsp_hit, op_vld;
    logic [CNT_W-1:0] rsp_cnt;
    logic [OP_W-1:0] op_data;

    always #10 clk = ~clk;

    slice_store dut (
        .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .wr_pc(wr_pc), .wr_cnt(wr_cnt),
        .wr_vld(wr_vld), .wr_op(wr_op), .lk_req(lk_req), .lk_pc(lk_pc),
        .rsp_vld(rsp_vld), .rsp_hit(rsp_hit), .rsp_cnt(rsp_cnt),
        .op_vld(op_vld), .op_data(op_data)
    );

    // Reference model
    bit          mv [SETS][4];
    logic [31:0] mt [SETS][4];
    int          mc [SETS][4];
    logic [31:0] mo [SETS][4][MAX_LEN];
    logic [2:0]  mp [SETS];

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
        end
    endtask

    function automatic int m_set(input logic [31:0] pc);
        return int'(pc[2 +: SET_W]);
    endfunction

    function automatic logic [31:0] mk_pc(input int t, input int s);
        return (32'(t) << 6) | (32'(s) << 2);
    endfunction

    function automatic bit m_find(input logic [31:0] pc, output int way);
        int s = m_set(pc);
        way = 0;
        for (int w = 0; w < 4; w++) if (mv[s][w] && mt[s][w] == pc) begin way = w; return 1'b1; end
        return 1'b0;
    endfunction

    function automatic int m_victim(input logic [2:0] b);
        if (!b[0]) return b[1] ? 1 : 0;
        return b[2] ? 3 : 2;
    endfunction

    function automatic logic [2:0] m_touch(input logic [2:0] b, input int w);
        logic [2:0] r = b;
        r[0] = (w < 2);
        if (w < 2) r[1] = (w == 0);
        else       r[2] = (w == 2);
        return r;
    endfunction

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_write(input logic [31:0] pc, input int cnt, input int gap);
        logic [31:0] w [MAX_LEN];
        int s, way, f;
        bit h, fr;
        for (int i = 0; i < MAX_LEN; i++) w[i] = $urandom;
        wr_start = 1; wr_pc = pc; wr_cnt = CNT_W'(cnt); wr_op = w[0];
        cyc();
        wr_start = 0;
        if (cnt >= 1 && cnt <= MAX_LEN) begin
            for (int i = 1; i < cnt; i++) begin
                for (int g = 0; g < gap; g++) begin wr_vld = 0; cyc(); end
                wr_vld = 1; wr_op = w[i];
                cyc();
                wr_vld = 0;
            end
            s = m_set(pc);
            h = m_find(pc, way);
            if (!h) begin
                fr = 0; f = 0;
                for (int k = 3; k >= 0; k--) if (!mv[s][k]) begin fr = 1; f = k; end
                way = fr ? f : m_victim(mp[s]);
            end
            mv[s][way] = 1; mt[s][way] = pc; mc[s][way] = cnt;
            for (int i = 0; i < MAX_LEN; i++) mo[s][way][i] = w[i];
            mp[s] = m_touch(mp[s], way);
        end else begin
            for (int i = 0; i < 3; i++) begin wr_vld = 1; wr_op = $urandom; cyc(); end
            wr_vld = 0;
        end
    endtask

    task automatic do_lookup(input logic [31:0] pc, input bit conf, input bit poke,
                             input logic [31:0] ppc, input string tag, output bit got);
        int way, c, s;
        bit h;
        logic [31:0] ex [MAX_LEN];
        s = m_set(pc);
        h = !conf && m_find(pc, way);
        c = h ? mc[s][way] : 0;
        for (int i = 0; i < MAX_LEN; i++) ex[i] = h ? mo[s][way][i] : '0;
        if (h) mp[s] = m_touch(mp[s], way);
        lk_req = 1; lk_pc = pc;
        cyc();
        lk_req = 0;
        got = rsp_hit;
        chk(rsp_vld == 1'b1, {tag, " R3 response valid"}, 32'(rsp_vld), 32'd1);
        chk(rsp_hit == h, {tag, " R3 hit flag"}, 32'(rsp_hit), 32'(h));
        chk(int'(rsp_cnt) == c, {tag, " R3 count"}, 32'(rsp_cnt), 32'(c));
        if (h) begin
            chk(op_vld && op_data == ex[0], {tag, " R4 word 0"}, op_data, ex[0]);
            for (int i = 1; i < c; i++) begin
                if (poke && i == 1) begin lk_req = 1; lk_pc = ppc; end
                cyc();
                lk_req = 0;
                chk(op_vld && op_data == ex[i], {tag, " R4 word"}, op_data, ex[i]);
                chk(!rsp_vld, {tag, " R3 no response during stream"}, 32'(rsp_vld), 32'd0);
            end
            cyc();
            chk(!op_vld, {tag, " R4 stream length"}, 32'(op_vld), 32'd0);
        end else begin
            chk(!op_vld, {tag, " R3 miss gives no data"}, 32'(op_vld), 32'd0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        bit g;
        int hits;
        void'($urandom(32'd7391));
        for (int s = 0; s < SETS; s++) begin
            mp[s] = '0;
            for (int w = 0; w < 4; w++) begin mv[s][w] = 0; mt[s][w] = '0; mc[s][w] = 0; end
        end
        @(negedge clk);
        repeat (3) cyc();
        rst_n = 1;
        cyc();
        chk(!rsp_vld && !op_vld, "R1 outputs idle after reset", {30'd0, rsp_vld, op_vld}, 32'd0);
        do_lookup(mk_pc(1, 5), 0, 0, 0, "R1", g);

        // R2: single-word and full-length bursts with gaps
        do_write(mk_pc(1, 5), 1, 0);
        do_lookup(mk_pc(1, 5), 0, 0, 0, "R2", g);
        do_write(mk_pc(2, 5), 16, 1);
        do_lookup(mk_pc(2, 5), 0, 0, 0, "R10", g);

        // R6: fill the set, then overwrite one lead in place
        do_write(mk_pc(3, 5), 4, 0);
        do_write(mk_pc(4, 5), 7, 2);
        do_write(mk_pc(1, 5), 5, 0);
        for (int t = 1; t <= 4; t++) do_lookup(mk_pc(t, 5), 0, 0, 0, "R6", g);

        // R7: a fifth lead evicts exactly one line
        do_write(mk_pc(5, 5), 3, 0);
        hits = 0;
        for (int t = 1; t <= 5; t++) begin
            do_lookup(mk_pc(t, 5), 0, 0, 0, "R7", g);
            hits += int'(g);
        end
        chk(hits == 4, "R7 one line evicted", 32'(hits), 32'd4);

        // R9: rejected lengths leave the store unchanged
        do_write(mk_pc(5, 5), 0, 0);
        do_write(mk_pc(5, 5), 20, 0);
        do_lookup(mk_pc(5, 5), 0, 0, 0, "R9", g);
        do_write(mk_pc(6, 9), 0, 0);
        do_lookup(mk_pc(6, 9), 0, 0, 0, "R9", g);

        // R8: lookups into the set of an active burst miss
        do_write(mk_pc(1, 6), 3, 0);
        fork
            do_write(mk_pc(2, 6), 4, 0);
            begin
                for (int k = 0; k < 4; k++) do_lookup(mk_pc(1, 6), 1, 0, 0, "R8", g);
            end
        join
        do_lookup(mk_pc(1, 6), 0, 0, 0, "R8", g);
        do_lookup(mk_pc(2, 6), 0, 0, 0, "R2", g);

        // R11: a stream keeps old contents while the line is rewritten
        do_write(mk_pc(1, 7), 16, 0);
        fork
            do_lookup(mk_pc(1, 7), 0, 0, 0, "R11", g);
            begin cyc(); do_write(mk_pc(1, 7), 2, 0); end
        join
        do_lookup(mk_pc(1, 7), 0, 0, 0, "R11", g);

        // R3: a lookup during a stream is ignored
        do_write(mk_pc(1, 8), 4, 0);
        do_write(mk_pc(2, 8), 2, 0);
        do_lookup(mk_pc(1, 8), 0, 1, mk_pc(2, 8), "R3", g);
        do_lookup(mk_pc(2, 8), 0, 0, 0, "R3", g);

        // R5/R7: random mix over three sets with six leads each
        for (int n = 0; n < 400; n++) begin
            int r, cnt;
            logic [31:0] pc;
            r  = int'($urandom % 10);
            pc = mk_pc(int'($urandom % 6), int'($urandom % 3));
            if (r < 5) begin
                if (r == 0) cnt = ($urandom % 2 == 0) ? 0 : 17 + int'($urandom % 15);
                else        cnt = 1 + int'($urandom % 16);
                do_write(pc, cnt, int'($urandom % 2));
            end else begin
                do_lookup(pc, 0, 0, 0, "R5", g);
            end
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule